// File: doc/BRIEF.md
# SDRAM Bank State Checker

This block sits beside an SDRAM controller and follows the decoded command stream it sends to a four-bank device. For each bank it keeps an open or idle flag and the row that was last activated. It also runs down the guard intervals that follow a precharge, an auto-precharged access and a mode-register load. Every command is judged against that state. A legal command updates the state. An illegal one leaves all state as it was and raises a one-cycle error pulse with a code.

A command is presented on a 3-bit code together with a bank select and a 13-bit address, and it is sampled on the rising clock edge. Results are registered, so the effect of a command sampled at the end of cycle c shows up in cycle c+1. The guard intervals are `T_MRD`, `T_RP` and the burst length `BURST`, all parameters with defaults of 2, 3 and 4 cycles.

Top module: `sdram_bank_checker`

## Requirements
- R1: A mode load (code 1) sent while any bank is open or not yet ready is refused with error code 1 and changes nothing.
- R2: A mode load sent while every bank is idle and ready, but with address bit 12 high, is refused with error code 5.
- R3: An activate (code 2) to an idle, ready bank opens it in the next cycle and shows the full address as that bank's open row.
- R4: An activate to a bank that is already open is refused with error code 2. The row and the open flag of that bank are kept.
- R5: A read (code 3) or write (code 4) to a bank that is not open is refused with error code 3.
- R6: A read or write to an open bank with address bit 10 high is an auto-precharged access. If it is accepted in cycle c, the bank stays open through cycle c+BURST, reads idle from cycle c+BURST+1 and reads ready from cycle c+BURST+T_RP.
- R7: A precharge (code 5) with address bit 10 high closes every open bank, whatever the bank select. With bit 10 low it closes only the selected bank. A precharge of an idle bank has no effect.
- R8: A bank closed by a precharge in cycle c reads not ready from cycle c+1 up to cycle c+T_RP. An activate to a bank that is not ready is refused with error code 4.
- R9: After a mode load accepted in cycle c, any command with code 1 to 5 in cycles c+1 to c+T_MRD-1 is refused with error code 4. This check takes priority over every other check.
- R10: The error pulse is high for exactly the cycle after a refused command, and error code is 0 whenever the pulse is low. A refused command changes no bank state.
- R11: Command codes 0, 6 and 7 are no-operations and never raise an error.
- R12: A synchronous reset leaves all banks idle and ready, the mode timer clear and the error outputs at 0.
- R13: While an auto-precharge is pending on a bank, a read, write or precharge aimed at it is refused with error code 4. A precharge with bit 10 high is refused if any bank has one pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Command code: 0 nop, 1 mode load, 2 activate, 3 read, 4 write, 5 precharge |
| ba | input | 2 | Bank select |
| addr | input | 13 | Address: row on activate, bit 10 auto/all flag, bit 12 reserved on mode load |
| bank_open | output | 4 | Open flag per bank |
| open_row | output | 52 | Open row per bank, bank b at bits [13b+12:13b] |
| bank_ready | output | 4 | Bank has no guard interval running |
| err_pulse | output | 1 | One-cycle flag for a refused command |
| err_code | output | 3 | Reason: 1 banks busy for mode load, 2 row open, 3 bank idle, 4 timing, 5 reserved bit set |

## Verification
The assertions assume that `cmd`, `ba` and `addr` are known at every sampled edge outside reset. They also assume that the parameters keep `T_RP` and `BURST` at 1 or more. The stimulus meets both assumptions. It drives every input at the falling edge from a seeded random source, and it also sends codes 6 and 7 so that the no-operation path is exercised. The random mix is weighted toward activates and precharges so that banks keep opening and closing. It sets bit 12 on a quarter of mode loads. A directed opening sequence makes sure that accepted mode loads, auto-precharge windows and early activates all occur.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  localparam logic [2:0] C_NOP   = 3'd0;
  localparam logic [2:0] C_MODE  = 3'd1;
  localparam logic [2:0] C_ACT   = 3'd2;
  localparam logic [2:0] C_READ  = 3'd3;
  localparam logic [2:0] C_WRITE = 3'd4;
  localparam logic [2:0] C_PRE   = 3'd5;

  typedef enum logic [2:0] {
    E_NONE      = 3'd0,
    E_MODE_BUSY = 3'd1,
    E_ROW_OPEN  = 3'd2,
    E_BANK_IDLE = 3'd3,
    E_TIMING    = 3'd4,
    E_MODE_ADDR = 3'd5
  } err_e;

  // Codes 1..5 are executable; everything else acts as a no-operation.
  function automatic logic is_exec(input logic [2:0] c);
    return (c >= C_MODE) && (c <= C_PRE);
  endfunction

  function automatic logic is_access(input logic [2:0] c);
    return (c == C_READ) || (c == C_WRITE);
  endfunction

  // Counter start value for an auto-precharged access.
  function automatic int unsigned ap_span(input int unsigned bl, input int unsigned trp);
    return bl + trp - 1;
  endfunction

endpackage

// File: rtl/sbc_mode_timer.sv
module sbc_mode_timer #(
  parameter int unsigned T_MRD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int unsigned CW = (T_MRD > 1) ? $clog2(T_MRD) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= CW'(T_MRD > 0 ? T_MRD - 1 : 0);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  generate
    if (T_MRD > 1) begin : g_chk
      // R9
      mrd_window_chk: assert property (@(posedge clk) disable iff (rst) load |=> busy);
    end
  endgenerate
endmodule

// File: rtl/sbc_bank.sv
module sbc_bank #(
  parameter int unsigned AW    = 13,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned BURST = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_act,
  input  logic          do_pre,
  input  logic          do_ap,
  input  logic [AW-1:0] row_in,
  output logic          is_open,
  output logic [AW-1:0] row,
  output logic          ready,
  output logic          ap_pend
);
  localparam int unsigned SPAN = sbc_pkg::ap_span(BURST, T_RP);
  localparam int unsigned CW   = $clog2(SPAN + 1);

  logic [CW-1:0] cnt;
  logic          close_now;

  assign close_now = ap_pend && (cnt == CW'(T_RP));

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      row     <= '0;
      cnt     <= '0;
      ap_pend <= 1'b0;
    end else if (do_act) begin
      is_open <= 1'b1;
      row     <= row_in;
    end else if (do_pre) begin
      is_open <= 1'b0;
      cnt     <= CW'(T_RP - 1);
    end else if (do_ap) begin
      ap_pend <= 1'b1;
      cnt     <= CW'(SPAN);
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (close_now) is_open <= 1'b0;
      if (cnt == CW'(1)) ap_pend <= 1'b0;
    end
  end

  assign ready = (cnt == '0);

  // R4
  act_idle_chk: assert property (@(posedge clk) disable iff (rst) do_act |-> (!is_open && ready));
  // R8
  pre_guard_chk: assert property (@(posedge clk) disable iff (rst) do_pre |=> (!ready && !is_open));
  // R6
  ap_hold_chk: assert property (@(posedge clk) disable iff (rst) do_ap |=> (is_open && !ready && ap_pend));
endmodule

// File: rtl/sdram_bank_checker.sv
module sdram_bank_checker #(
  parameter int unsigned NB      = 4,
  parameter int unsigned BAW     = 2,
  parameter int unsigned AW      = 13,
  parameter int unsigned T_MRD   = 2,
  parameter int unsigned T_RP    = 3,
  parameter int unsigned BURST   = 4,
  parameter int unsigned AP_BIT  = 10,
  parameter int unsigned RSV_BIT = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd,
  input  logic [BAW-1:0]   ba,
  input  logic [AW-1:0]    addr,
  output logic [NB-1:0]    bank_open,
  output logic [NB*AW-1:0] open_row,
  output logic [NB-1:0]    bank_ready,
  output logic             err_pulse,
  output logic [2:0]       err_code
);
  import sbc_pkg::*;

  logic [NB-1:0] ap_v;
  logic [NB-1:0] do_act, do_pre, do_ap;
  logic          mrd_busy, accept, mode_ok, exec;
  logic          sel_open, sel_ready, sel_ap;
  err_e          code_n;

  assign exec      = is_exec(cmd);
  assign sel_open  = bank_open[ba];
  assign sel_ready = bank_ready[ba];
  assign sel_ap    = ap_v[ba];

  always_comb begin
    code_n = E_NONE;
    if (exec && mrd_busy) code_n = E_TIMING;
    else begin
      case (cmd)
        C_MODE: begin
          if ((|bank_open) || !(&bank_ready)) code_n = E_MODE_BUSY;
          else if (addr[RSV_BIT])             code_n = E_MODE_ADDR;
        end
        C_ACT: begin
          if (sel_open)        code_n = E_ROW_OPEN;
          else if (!sel_ready) code_n = E_TIMING;
        end
        C_READ, C_WRITE: begin
          if (!sel_open)       code_n = E_BANK_IDLE;
          else if (!sel_ready) code_n = E_TIMING;
        end
        C_PRE: begin
          if (addr[AP_BIT] ? (|ap_v) : sel_ap) code_n = E_TIMING;
        end
        default: code_n = E_NONE;
      endcase
    end
  end

  assign accept  = exec && (code_n == E_NONE);
  assign mode_ok = accept && (cmd == C_MODE);

  sbc_mode_timer #(.T_MRD(T_MRD)) u_mrd (
    .clk(clk), .rst(rst), .load(mode_ok), .busy(mrd_busy)
  );

  generate
    for (genvar g = 0; g < NB; g++) begin : g_bank
      logic hit;
      assign hit       = (ba == BAW'(g));
      assign do_act[g] = accept && (cmd == C_ACT) && hit;
      assign do_pre[g] = accept && (cmd == C_PRE) && (addr[AP_BIT] || hit) && bank_open[g];
      assign do_ap[g]  = accept && is_access(cmd) && addr[AP_BIT] && hit;

      sbc_bank #(.AW(AW), .T_RP(T_RP), .BURST(BURST)) u_bank (
        .clk(clk), .rst(rst),
        .do_act(do_act[g]), .do_pre(do_pre[g]), .do_ap(do_ap[g]),
        .row_in(addr),
        .is_open(bank_open[g]), .row(open_row[g*AW +: AW]),
        .ready(bank_ready[g]), .ap_pend(ap_v[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse <= 1'b0;
      err_code  <= 3'd0;
    end else begin
      err_pulse <= (code_n != E_NONE);
      err_code  <= code_n;
    end
  end

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst) !err_pulse |-> (err_code == 3'd0));
  // R1
  mode_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_MODE && !mrd_busy && (|bank_open)) |=> (err_pulse && err_code == 3'd1));
  // R9
  mrd_block_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && mrd_busy) |=> (err_code == 3'd4));
  // R11
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst) !exec |=> !err_pulse);
  // R10
  reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && !accept) |=> ($stable(bank_open) || ($past(ap_v) != '0)));
endmodule

// File: tb/sim_sdram_bank_checker.sv
`timescale 1ns/1ps
module sim_sdram_bank_checker;
  localparam int TMRD = 2, TRP = 3, BL = 4, BIG = 32'h7fffffff;

  logic        clk = 1'b0, rst = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  ba = 2'd0;
  logic [12:0] addr = '0;
  logic [3:0]  bank_open, bank_ready;
  logic [51:0] open_row;
  logic        err_pulse;
  logic [2:0]  err_code;

  int checks = 0, fails = 0, now = 0, mrd_at = 0;
  int ready_at[4], close_at[4];
  bit open_f[4], ap_f[4];
  logic [12:0] row_m[4];
  logic [2:0]  exp_err = 3'd0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdram_bank_checker u0 (.clk(clk), .rst(rst), .cmd(cmd), .ba(ba), .addr(addr),
    .bank_open(bank_open), .open_row(open_row), .bank_ready(bank_ready),
    .err_pulse(err_pulse), .err_code(err_code));

  function automatic bit m_open(int b);
    return open_f[b] && (now < close_at[b]);
  endfunction
  function automatic bit m_ready(int b);
    return now >= ready_at[b];
  endfunction
  function automatic bit m_ap(int b);
    return ap_f[b] && (now < ready_at[b]);
  endfunction

  function automatic string tag_of(logic [2:0] e);
    case (e)
      3'd1: return "R1";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R8/R9/R13";
      3'd5: return "R2";
      default: return "R10/R11";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: got %0h expected %0h", tag, now, act, exp);
    end
  endtask

  task automatic m_reset();
    now = 0; mrd_at = 0; exp_err = 3'd0;
    for (int b = 0; b < 4; b++) begin
      ready_at[b] = 0; close_at[b] = BIG; open_f[b] = 0; ap_f[b] = 0; row_m[b] = '0;
    end
  endtask

  task automatic check_now();
    chk(tag_of(exp_err), {err_pulse, err_code}, {exp_err != 3'd0, exp_err});
    for (int b = 0; b < 4; b++) begin
      chk("R6/R7 open", bank_open[b], m_open(b));
      chk("R8 ready", bank_ready[b], m_ready(b));
      if (m_open(b)) chk("R3 row", open_row[b*13 +: 13], row_m[b]);
    end
  endtask

  task automatic m_eval(logic [2:0] c, int b, logic [12:0] a);
    logic [2:0] e;
    bit anyo, allr, anyap;
    anyo = 0; allr = 1; anyap = 0;
    for (int k = 0; k < 4; k++) begin
      anyo |= m_open(k); allr &= m_ready(k); anyap |= m_ap(k);
    end
    e = 3'd0;
    if (c >= 3'd1 && c <= 3'd5 && now < mrd_at) e = 3'd4;
    else if (c == 3'd1) e = (anyo || !allr) ? 3'd1 : (a[12] ? 3'd5 : 3'd0);
    else if (c == 3'd2) e = m_open(b) ? 3'd2 : (!m_ready(b) ? 3'd4 : 3'd0);
    else if (c == 3'd3 || c == 3'd4) e = !m_open(b) ? 3'd3 : (!m_ready(b) ? 3'd4 : 3'd0);
    else if (c == 3'd5) e = (a[10] ? anyap : m_ap(b)) ? 3'd4 : 3'd0;
    if (e == 3'd0) begin
      if (c == 3'd1) mrd_at = now + TMRD;
      if (c == 3'd2) begin open_f[b] = 1; close_at[b] = BIG; row_m[b] = a; end
      if (c == 3'd5)
        for (int k = 0; k < 4; k++)
          if ((a[10] || k == b) && m_open(k)) begin
            close_at[k] = now + 1; ready_at[k] = now + TRP; ap_f[k] = 0;
          end
      if ((c == 3'd3 || c == 3'd4) && a[10]) begin
        close_at[b] = now + BL + 1; ready_at[b] = now + BL + TRP; ap_f[b] = 1;
      end
    end
    exp_err = e;
  endtask

  task automatic step(logic [2:0] c, int b, logic [12:0] a);
    check_now();
    cmd = c; ba = 2'(b); addr = a;
    @(posedge clk);
    m_eval(c, b, a);
    now++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    cmd = 3'd0; rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_reset();
    check_now(); // R12
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_reset();
    @(negedge clk);
    do_reset();
    step(3'd1, 0, 13'h0000);             // accepted mode load
    step(3'd2, 1, 13'h1abc);             // R9 inside window
    step(3'd2, 1, 13'h1abc);             // R3 opens
    step(3'd2, 1, 13'h0123);             // R4 row already open
    step(3'd3, 2, 13'h0000);             // R5 idle bank
    step(3'd1, 0, 13'h0000);             // R1 bank open
    step(3'd3, 1, 13'h0400);             // R6 auto-precharge read
    step(3'd0, 0, 13'h0000);
    step(3'd4, 1, 13'h0000);             // R13 access while pending
    step(3'd5, 1, 13'h0000);             // R13 precharge while pending
    for (int i = 0; i < 8; i++) step(3'd0, 0, 13'h0);
    step(3'd2, 0, 13'h0055);
    step(3'd2, 3, 13'h0777);
    step(3'd5, 2, 13'h0400);             // R7 all banks regardless of select
    step(3'd2, 3, 13'h0001);             // R8 too early
    step(3'd6, 3, 13'h1fff);             // R11 unused code
    for (int i = 0; i < 3; i++) step(3'd0, 0, 13'h0);
    step(3'd1, 0, 13'h1000);             // R2 reserved bit
    step(3'd2, 2, 13'h0222);
    step(3'd5, 2, 13'h0000);             // R7 single bank
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 16;
      logic [2:0] c;
      logic [12:0] a = 13'($urandom);
      if (r < 3) c = 3'd0;
      else if (r < 4) begin c = 3'd1; a[12] = ($urandom % 4 == 0); end
      else if (r < 9) c = 3'd2;
      else if (r < 11) c = 3'd3;
      else if (r < 12) c = 3'd4;
      else if (r < 15) c = 3'd5;
      else c = 3'(6 + ($urandom % 2));
      if (c != 3'd2) a[10] = ($urandom % 3 == 0);
      step(c, $urandom % 4, a);
      if (i == 1500) do_reset();
    end
    check_now();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule